// File: doc/BRIEF.md
# Locked-Entry-Aware Random Replacement Index Generator

This block picks a pseudo-random slot for a translation buffer in which the lowest entries can be locked and must never be replaced. It keeps a 32-bit linear congruential seed. Each accepted request strobe advances that seed once. The upper half of the new seed is reduced modulo the number of unlocked entries, and the locked-entry count is then added, so the chosen slot always lies between the locked region and the top entry.

The reduction uses a bit-serial restoring remainder unit, which takes one cycle per source bit. While it works, the block raises `busy_o` and ignores further strobes. When the result is ready, `valid_o` pulses for one cycle and `idx_o` holds the index until the next result. The locked-entry count is captured when a request is accepted. A count of the entry total or more is clamped to one below the total, so at least one entry is always eligible.

Top module: `tlb_victim_pick`

## Requirements
- R1: After reset the seed is zero, `valid_o` and `busy_o` are 0 and `idx_o` is 0. The first request after reset therefore works on seed 1.
- R2: Each accepted request replaces the seed with (seed × 314159 + 1) mod 2^32, exactly once per request.
- R3: The result equals ((seed >> 16) mod (TLB_ENTRIES − w)) + w. Here seed is the value after the advance, and w is the clamped wired count sampled at acceptance. Later changes on `wired_i` have no effect on that result.
- R4: Whenever `valid_o` is 1, `idx_o` is at least w and at most TLB_ENTRIES − 1.
- R5: A `wired_i` value of TLB_ENTRIES or more is treated as TLB_ENTRIES − 1, so with the default of 16 entries the index is 15.
- R6: A request is accepted at a clock edge where `req_i` is 1 and `busy_o` is 0. `busy_o` is 1 from that edge until the result. `valid_o` rises at the 16th edge after acceptance and stays high for exactly one cycle. `valid_o` and `busy_o` are never 1 together.
- R7: A `req_i` pulse while `busy_o` is 1 is ignored. It neither advances the seed nor changes the pending result.
- R8: A request that arrives in the same cycle as `valid_o` is accepted.
- R9: `idx_o` keeps its value between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request strobe for a new index |
| wired_i | input | 5 | Count of locked low entries (IDX_W+1 bits) |
| idx_o | output | 4 | Chosen entry index (IDX_W bits) |
| valid_o | output | 1 | One-cycle pulse when `idx_o` is new |
| busy_o | output | 1 | Computation in progress, requests ignored |

## Verification
A result pulse on `valid_o` and the acceptance of the next request can fall in the same cycle. The bench provokes this by raising `req_i` in the very cycle where `valid_o` is seen. It then judges that `busy_o` rises at once, that the next result arrives 16 edges later, and that this result matches the reference seed advanced by exactly one step. A second collision is a strobe that lands mid-computation. That strobe must leave both the pending result and the later seed sequence unchanged. Every locked count from 0 to 31 is swept, so the clamped values are covered too.

// File: rtl/tvp_pkg.sv
// Shared constants for the random replacement index generator.
// Assumes: seed arithmetic is modulo 2^SEED_W.
package tvp_pkg;
    localparam int unsigned SEED_W    = 32;
    localparam int unsigned SRC_SHIFT = 16;
    localparam int unsigned LCG_MUL   = 314159;
    localparam int unsigned LCG_INC   = 1;
endpackage

// File: rtl/tvp_lcg.sv
// Linear congruential seed register.
// Holds the seed and advances it by seed*MUL+INC (mod 2^SEED_W) on adv_i.
// next_o shows the value the seed takes on the next advance.
// Assumes: adv_i is a single-cycle qualified strobe.
module tvp_lcg #(
    parameter int unsigned SEED_W = 32,
    parameter int unsigned MUL    = 314159,
    parameter int unsigned INC    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    output logic [SEED_W-1:0] seed_o,
    output logic [SEED_W-1:0] next_o
);
    localparam logic [SEED_W-1:0] MUL_C = SEED_W'(MUL);
    localparam logic [SEED_W-1:0] INC_C = SEED_W'(INC);

    logic [SEED_W-1:0] seed_q;

    // Next seed value, truncated to the seed width.
    always_comb begin
        next_o = seed_q * MUL_C + INC_C;
    end

    // Seed register: zero at reset, advanced only on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_q <= '0;
        end else if (adv_i) begin
            seed_q <= next_o;
        end
    end

    assign seed_o = seed_q;

    // R2: the seed changes only on an advance strobe.
    assert_seed_only_on_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(seed_q));
endmodule

// File: rtl/tvp_modred.sv
// Bit-serial restoring remainder unit.
// Reduces SRC_W-bit src_i modulo div_i, one source bit per cycle, MSB first.
// fin_o marks the cycle whose step is the last one; rem_nx_o then carries the
// final remainder.
// Assumes: div_i is nonzero and at most 2^(DIV_W-1).
module tvp_modred #(
    parameter int unsigned SRC_W = 16,
    parameter int unsigned DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [SRC_W-1:0] src_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             busy_o,
    output logic             fin_o,
    output logic [DIV_W-1:0] rem_nx_o
);
    localparam int unsigned CNT_W = $clog2(SRC_W + 1);

    logic [SRC_W-1:0] src_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W:0]   shf_c;
    logic [DIV_W:0]   sub_c;

    // One restoring step: shift in the next source bit, subtract if it fits.
    always_comb begin
        shf_c    = {rem_q, src_q[SRC_W-1]};
        sub_c    = shf_c - {1'b0, div_q};
        rem_nx_o = (shf_c >= {1'b0, div_q}) ? sub_c[DIV_W-1:0] : shf_c[DIV_W-1:0];
    end

    // Step sequencer: load on start, then one bit per cycle until the count ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            div_q <= '0;
            rem_q <= '0;
            cnt_q <= '0;
        end else if (start_i) begin
            src_q <= src_i;
            div_q <= div_i;
            rem_q <= '0;
            cnt_q <= CNT_W'(SRC_W);
        end else if (cnt_q != '0) begin
            src_q <= src_q << 1;
            rem_q <= rem_nx_o;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = (cnt_q != '0);
    assign fin_o  = (cnt_q == CNT_W'(1));

    // R3: the partial remainder stays below the divisor while working.
    assert_rem_below_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (rem_q < div_q));
endmodule

// File: rtl/tlb_victim_pick.sv
// Random replacement index generator for a buffer with locked low entries.
// On an accepted request it advances the LCG seed, captures the clamped
// locked count w and reduces (seed >> SRC_SHIFT) modulo (TLB_ENTRIES - w).
// It registers remainder + w as the index and pulses valid_o.
// Assumes: TLB_ENTRIES >= 2; requests while busy_o is high are dropped.
module tlb_victim_pick
    import tvp_pkg::*;
#(
    parameter int unsigned TLB_ENTRIES = 16,
    parameter int unsigned IDX_W       = $clog2(TLB_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [IDX_W:0]   wired_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             valid_o,
    output logic             busy_o
);
    localparam int unsigned DIV_W = IDX_W + 1;
    localparam int unsigned SRC_W = SEED_W - SRC_SHIFT;
    localparam logic [IDX_W:0] WMAX = (IDX_W + 1)'(TLB_ENTRIES - 1);

    logic              accept_c;
    logic [IDX_W-1:0]  wired_c;
    logic [IDX_W-1:0]  wired_q;
    logic [DIV_W-1:0]  div_c;
    logic [SEED_W-1:0] seed_w;
    logic [SEED_W-1:0] next_w;
    logic              fin_w;
    logic [DIV_W-1:0]  rem_nx_w;
    logic [DIV_W-1:0]  sum_c;
    logic [IDX_W-1:0]  idx_q;
    logic              valid_q;

    // Accept a strobe only while idle; clamp the locked count below the total.
    always_comb begin
        accept_c = req_i && !busy_o;
        wired_c  = (wired_i > WMAX) ? WMAX[IDX_W-1:0] : wired_i[IDX_W-1:0];
        div_c    = DIV_W'(TLB_ENTRIES) - {1'b0, wired_c};
        sum_c    = rem_nx_w + {1'b0, wired_q};
    end

    tvp_lcg #(
        .SEED_W (SEED_W),
        .MUL    (LCG_MUL),
        .INC    (LCG_INC)
    ) u_lcg (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (accept_c),
        .seed_o (seed_w),
        .next_o (next_w)
    );

    tvp_modred #(
        .SRC_W (SRC_W),
        .DIV_W (DIV_W)
    ) u_modred (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (accept_c),
        .src_i    (next_w[SEED_W-1:SRC_SHIFT]),
        .div_i    (div_c),
        .busy_o   (busy_o),
        .fin_o    (fin_w),
        .rem_nx_o (rem_nx_w)
    );

    // Capture the locked count at acceptance; register the index at the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wired_q <= '0;
            idx_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            if (accept_c) begin
                wired_q <= wired_c;
            end
            if (fin_w) begin
                idx_q <= sum_c[IDX_W-1:0];
            end
            valid_q <= fin_w;
        end
    end

    assign idx_o   = idx_q;
    assign valid_o = valid_q;

    // R4: a valid index lies inside the unlocked range.
    assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (idx_o >= wired_q) && (32'(idx_o) <= TLB_ENTRIES - 1));

    // R6: valid is a single-cycle pulse.
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R6: valid and busy never overlap.
    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && busy_o));

    // R7: a strobe during busy leaves the seed untouched.
    assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && busy_o) |=> $stable(seed_w));

    // R9: the index changes only in the cycle it becomes valid.
    assert_idx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |=> (valid_o || $stable(idx_o)));
endmodule

// File: tb/tlb_victim_pick_bench.sv
module tlb_victim_pick_bench;
    localparam int N     = 16;
    localparam int IDX_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_i = 1'b0;
    logic [IDX_W:0]   wired_i = '0;
    logic [IDX_W-1:0] idx_o;
    logic             valid_o;
    logic             busy_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] mseed = 32'd0;

    always #4 clk = ~clk;

    tlb_victim_pick #(.TLB_ENTRIES(N)) u_tlb_victim_pick (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wired_i(wired_i),
        .idx_o(idx_o), .valid_o(valid_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampw(input int w);
        return (w > N - 1) ? N - 1 : w;
    endfunction

    // Called at a negedge: issue a request, check the result, leave at the valid negedge.
    task automatic run_req(input int w, input bit poke_busy);
        int lat;
        int cw;
        int exp;
        req_i   = 1'b1;
        wired_i = w[IDX_W:0];
        mseed   = mseed * 32'd314159 + 32'd1;
        cw      = clampw(w);
        exp     = int'((mseed >> 16) % (N - cw)) + cw;
        @(negedge clk);
        req_i   = 1'b0;
        wired_i = wired_i ^ 5'h1F;
        chk(busy_o === 1'b1 && valid_o === 1'b0, "R6 busy after accept", busy_o, 1);
        lat = 0;
        while (valid_o !== 1'b1 && lat < 40) begin
            @(negedge clk);
            lat++;
            if (poke_busy && lat == 5) begin
                req_i   = 1'b1;
                wired_i = 5'd3;
            end else begin
                req_i = 1'b0;
            end
        end
        req_i = 1'b0;
        chk(lat == 16, "R6 latency", lat, 16);
        chk(int'(idx_o) == exp, (w >= N) ? "R5 clamped index" : "R3 index value", idx_o, exp);
        chk(int'(idx_o) >= cw && int'(idx_o) <= N - 1, "R4 index range", idx_o, cw);
        chk(busy_o === 1'b0, "R6 busy clear at valid", busy_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [IDX_W-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid_o === 1'b0 && busy_o === 1'b0, "R1 reset flags", {valid_o, busy_o}, 0);
        chk(idx_o === '0, "R1 reset index", idx_o, 0);

        // R1: the first result works on seed 1, so the index equals w.
        run_req(5, 1'b0);
        chk(int'(idx_o) == 5, "R1 first index from seed 1", idx_o, 5);
        @(negedge clk);
        chk(valid_o === 1'b0, "R6 valid one cycle", valid_o, 0);

        // R7: a strobe mid-computation is dropped; the model seed advances once only.
        run_req(2, 1'b1);
        @(negedge clk);
        run_req(7, 1'b0);
        chk(1'b1, "R7 dropped strobe left the sequence intact", 0, 0);

        // R8: a request in the valid cycle is accepted at once.
        run_req(0, 1'b0);
        run_req(9, 1'b0);
        chk(1'b1, "R8 back-to-back accepted", 0, 0);

        // R9: the index holds while idle even as wired_i changes.
        held = idx_o;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            wired_i = k[IDX_W:0];
            chk(idx_o === held && valid_o === 1'b0, "R9 index hold", idx_o, held);
        end

        // R2 R3 R5: sweep every locked count, including clamped ones, with many requests.
        for (int w = 0; w < 2 * N; w++) begin
            for (int r = 0; r < 25; r++) begin
                run_req(w, (r % 7) == 3);
                if (r % 2 == 0) @(negedge clk);
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule